// File: doc/BRIEF.md
# Receive FIFO Stall Timeout Watchdog

This block detects a receive FIFO that has gone quiet. A prescaler counts system clock cycles and emits one tick each time its count reaches or passes a limit equal to a fixed base (88000 cycles by default) shifted right by a 3-bit programmable amount. Every tick advances an 8-bit hang counter. Any FIFO push or pop clears both the prescaler and the hang counter. When the hang counter steps onto the programmed timeout value, the block raises a sticky raw interrupt flag.

The raw flag stays set until software writes one to the clear input. A separate interrupt enable masks the raw flag into a status bit, and that status bit drives the interrupt line. A timeout enable input gates the whole mechanism. The register that surrounds the block is expected to reset the timeout field to 16 and the timeout enable to 1. Those reset values are kept as package constants. The FIFO and the bus register decode are outside this block.

Top module: `stall_watchdog`

## Requirements
- R1: After reset the raw flag, the masked status and the interrupt line are all 0, and both counters are 0.
- R2: The tick limit is L = TICK_BASE >> shift_i. The prescaler emits a tick when its count is at least L, then restarts from 0, so ticks come every L+1 enabled cycles. L = 0 gives a tick on every cycle.
- R3: With timeout T >= 1 and no activity, the raw flag is first seen high right after the T*(L+1)-th rising edge that follows the last activity edge, or after that many enabled edges once the enable rises. It is still 0 one edge earlier.
- R4: An activity pulse (a push or a pop) clears the hang counter and the prescaler, so the full T*(L+1) delay starts again from that edge.
- R5: The hang counter stops at the timeout value. After one event, no further event occurs until new activity arrives, however long the FIFO stays idle.
- R6: A timeout value of 0 never sets the raw flag.
- R7: While enable_i is low, both counters are held at 0 and no new event is raised. A raw flag that is already set keeps its value.
- R8: The raw flag is sticky. It falls on the edge after clr_i is high, and only then.
- R9: status_o equals raw_o AND int_ena_i, and irq_o equals status_o.
- R10: If clr_i and a new stall event occur on the same edge, the raw flag is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| activity_i | input | 1 | High for one cycle for each FIFO push or pop |
| enable_i | input | 1 | Timeout mechanism enable |
| timeout_i | input | HANG_W (8) | Hang counter value that raises the event |
| shift_i | input | SHIFT_W (3) | Right-shift applied to TICK_BASE to form the tick limit |
| int_ena_i | input | 1 | Interrupt enable mask |
| clr_i | input | 1 | Write-one clear of the raw flag |
| raw_o | output | 1 | Sticky raw stall flag |
| status_o | output | 1 | Masked status (raw AND enable) |
| irq_o | output | 1 | Interrupt line |

## Verification
Several rules are checked by the assertions on every cycle. Activity or a low enable empties the counters on the next edge. An event is never raised while the block is disabled. An event always leaves the flag set. A clear without an event always drops it. The flag never falls on its own. Only the bench scenarios can show the end-to-end delay T*(L+1) for each shift setting, the behaviour with timeout 0, the saturation that prevents a second event, and the race between a clear and an event. In those scenarios the bench computes the expected edge count arithmetically.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int TIMEOUT_DEFAULT = 16;
  localparam bit ENABLE_DEFAULT  = 1'b1;

  // Tick limit: base period shifted right by the programmed amount
  function automatic int tick_limit(input int base, input int shift);
    return base >> shift;
  endfunction

  // Hang count that follows value h after one advance
  function automatic int next_hang(input int h);
    return h + 1;
  endfunction
endpackage

// File: rtl/stall_tick_prescaler.sv
module stall_tick_prescaler #(
  parameter int TICK_BASE = 88000,
  parameter int SHIFT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int PW = $clog2(TICK_BASE + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  always_comb begin
    limit  = PW'(stall_pkg::tick_limit(TICK_BASE, int'(shift_i)));
    tick_o = run_i && !restart_i && (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (!run_i || restart_i || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // R7: a disabled cycle leaves the prescaler empty
  assert_pre_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
  // R4: activity restarts the prescaler
  assert_pre_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/stall_hang_counter.sv
module stall_hang_counter #(
  parameter int HANG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [HANG_W-1:0] timeout_i,
  output logic              evt_o
);
  logic [HANG_W-1:0] hang_q;
  logic [HANG_W:0]   hang_nx;
  logic              adv;

  always_comb begin
    hang_nx = (HANG_W+1)'(stall_pkg::next_hang(int'(hang_q)));
    adv     = run_i && !restart_i && tick_i && (hang_q < timeout_i);
    evt_o   = adv && (hang_nx == {1'b0, timeout_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hang_q <= '0;
    else if (!run_i || restart_i) hang_q <= '0;
    else if (adv)                hang_q <= hang_nx[HANG_W-1:0];
  end

  // R4: activity empties the hang counter
  assert_hang_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> hang_q == '0);
  // R5: an event leaves the counter parked at the timeout value
  assert_hang_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> hang_q == $past(timeout_i));
endmodule

// File: rtl/stall_flag.sv
module stall_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  input  logic int_ena_i,
  output logic raw_o,
  output logic status_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     raw_o <= 1'b0;
    else if (evt_i) raw_o <= 1'b1;
    else if (clr_i) raw_o <= 1'b0;
  end

  always_comb status_o = raw_o & int_ena_i;

  // R10: an event always leaves the flag set, even against a clear
  assert_evt_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> raw_o);
  // R8: a clear without an event drops the flag
  assert_clr_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !raw_o);
  // R8: the flag never falls without a clear
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o && !clr_i) |=> raw_o);
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog #(
  parameter int TICK_BASE = 88000,
  parameter int SHIFT_W   = 3,
  parameter int HANG_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               activity_i,
  input  logic               enable_i,
  input  logic [HANG_W-1:0]  timeout_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               int_ena_i,
  input  logic               clr_i,
  output logic               raw_o,
  output logic               status_o,
  output logic               irq_o
);
  logic tick;
  logic stall_evt;

  stall_tick_prescaler #(.TICK_BASE(TICK_BASE), .SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(enable_i), .restart_i(activity_i),
    .shift_i(shift_i), .tick_o(tick));

  stall_hang_counter #(.HANG_W(HANG_W)) u_hang (
    .clk(clk), .rst_n(rst_n), .run_i(enable_i), .restart_i(activity_i),
    .tick_i(tick), .timeout_i(timeout_i), .evt_o(stall_evt));

  stall_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt_i(stall_evt), .clr_i(clr_i),
    .int_ena_i(int_ena_i), .raw_o(raw_o), .status_o(status_o));

  assign irq_o = status_o;

  // R7: no event while disabled
  assert_no_evt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !stall_evt);
  // R6: a zero timeout never produces an event
  assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == '0) |-> !stall_evt);
endmodule

// File: tb/stall_watchdog_test.sv
module stall_watchdog_test;
  localparam int BASE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0, en = 1'b1, iena = 1'b1, clr = 1'b0;
  logic [7:0] tmo = 8'd1;
  logic [2:0] sh = 3'd0;
  logic raw, st, irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  stall_watchdog #(.TICK_BASE(BASE), .SHIFT_W(3), .HANG_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .activity_i(act), .enable_i(en),
    .timeout_i(tmo), .shift_i(sh), .int_ena_i(iena), .clr_i(clr),
    .raw_o(raw), .status_o(st), .irq_o(irq));

  function automatic int delay_of(input int t, input int s);
    int lim;
    lim = BASE / (2 ** s);
    return t * (lim + 1);
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input logic act_v, input logic exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // activity pulse combined with a clear so each run starts clean
  task automatic kick();
    act = 1'b1; clr = 1'b1;
    step(1);
    act = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nd;
    step(2);
    check("R1 raw", raw, 1'b0);
    check("R1 status", st, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 raw after release", raw, 1'b0);

    // R2 R3: sweep every shift against several timeouts
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) begin
        sh = 3'(s);
        tmo = (k == 3) ? 8'd7 : 8'(k + 1);
        kick();
        nd = delay_of(int'(tmo), s);
        step(nd - 1);
        check("R3 before event", raw, 1'b0);
        step(1);
        check("R2 R3 at event", raw, 1'b1);
      end
    end

    // R5: no second event after a clear while still idle
    sh = 3'd3; tmo = 8'd3;
    kick();
    nd = delay_of(3, 3);
    step(nd);
    check("R5 first event", raw, 1'b1);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 clear drops", raw, 1'b0);
    step(4 * nd);
    check("R5 no retrigger", raw, 1'b0);

    // R4: activity part way restarts the delay
    kick();
    step(10);
    act = 1'b1; step(1); act = 1'b0;
    step(nd - 1);
    check("R4 restarted early", raw, 1'b0);
    step(1);
    check("R4 restarted event", raw, 1'b1);

    // R8: sticky over a long idle stretch, and R9 masking
    step(300);
    check("R8 sticky", raw, 1'b1);
    iena = 1'b0; step(1);
    check("R9 masked status", st, 1'b0);
    check("R9 masked irq", irq, 1'b0);
    check("R9 raw unmasked", raw, 1'b1);
    iena = 1'b1; step(1);
    check("R9 status", st, 1'b1);
    check("R9 irq", irq, 1'b1);

    // R7: disable keeps raw, blocks new events, restarts counting
    en = 1'b0; step(5);
    check("R7 raw kept while off", raw, 1'b1);
    clr = 1'b1; step(1); clr = 1'b0;
    step(4 * nd);
    check("R7 no event while off", raw, 1'b0);
    en = 1'b1;
    step(nd - 1);
    check("R7 enable restart early", raw, 1'b0);
    step(1);
    check("R7 enable restart event", raw, 1'b1);

    // R10: clear on the event edge loses to the event
    kick();
    step(nd - 1);
    check("R10 before race", raw, 1'b0);
    kick();
    step(nd - 1);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R10 event wins", raw, 1'b1);
    // clear one edge earlier: low then set
    kick();
    step(nd - 2);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 clear before event", raw, 1'b0);
    step(1);
    check("R3 event after clear", raw, 1'b1);

    // R6: zero timeout never fires
    tmo = 8'd0; sh = 3'd7;
    kick();
    step(500);
    check("R6 zero timeout", raw, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule